// File: doc/BRIEF.md
# Transmit Completion Queue and Interrupt Status

This block tracks transmitted frames whose outcome the host still has to handle. Each transmit-done event carries a packet number and a success flag. The event is either placed into a completion queue or, in auto-release mode with a good outcome, sent straight out as a memory-release request. The host finds the oldest pending packet number at the queue head and removes it with a pop strobe. The driver therefore keeps no list of its own of packets in flight, and transmission goes on while earlier completions wait.

The block also drives three interrupt status bits. Each one follows the state of a queue as a level and is not latched:

- completion queue not empty,
- transmit queue empty,
- receive queue not empty.

A combined interrupt line is the OR of each status bit gated by its enable. Clearing auto release gives one interrupt per packet. Setting it means only failures reach the queue, so the transmit-empty status gives one interrupt per burst.

The completion queue is as deep as the number of packet numbers that can be allocated, so it never has to refuse an entry in normal use.

Top module: `txc_irq_unit`

## Requirements
- R1: While `rst_n` is low, all of the following are 0: `head_valid`, `stat_tx`, `stat_txempty`, `stat_rx`, `irq` and `rel_valid`. After reset the completion queue is empty.
- R2: With `auto_release`=0, every `done_valid` event is queued, whatever the value of `done_ok`. Packet numbers leave the queue in the order they were pushed. A push into an empty queue shows at `head_pkt` with `head_valid`=1 one clock after the event.
- R3: With `auto_release`=1 and `done_ok`=1, the event is not queued, and `rel_valid` pulses for one clock one cycle later with `rel_pkt` equal to `done_pkt`. In every other case `rel_valid` stays 0.
- R4: With `auto_release`=1 and `done_ok`=0, the packet number is queued and no release is issued.
- R5: A `host_pop` with a non-empty queue removes the head, and the next entry is visible one clock later. A `host_pop` on an empty queue has no effect: `head_valid` stays 0 and a later push appears exactly once.
- R6: `stat_tx` equals `head_valid` in every cycle. It is 1 exactly when the completion queue is not empty.
- R7: `stat_txempty` is 1 one clock after a cycle in which `txq_count` is 0, and 0 one clock after a cycle in which it is non-zero.
- R8: `stat_rx` is 1 one clock after a cycle in which `rxq_count` is non-zero, and 0 otherwise.
- R9: `irq` is the OR of the status bits ANDed with the enable bits sampled in the same clock. The enable bits are `irq_en[0]` for TX, `irq_en[1]` for TX-empty and `irq_en[2]` for RX.
- R10: A push and a pop in the same cycle on a non-empty queue both take effect, so the occupancy stays the same and the order is kept.
- R11: The queue holds DEPTH entries (16 by default). After it is filled, all of them drain in push order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done_valid | input | 1 | Transmit-done event strobe |
| done_pkt | input | PKT_W | Packet number of the completed frame |
| done_ok | input | 1 | 1 = transmission succeeded |
| auto_release | input | 1 | Bypass the queue for successful frames |
| host_pop | input | 1 | Remove the head of the completion queue |
| txq_count | input | OCC_W | Packets waiting in the transmit queue |
| rxq_count | input | OCC_W | Packets waiting in the receive queue |
| irq_en | input | 3 | Enables: bit0 TX, bit1 TX-empty, bit2 RX |
| head_pkt | output | PKT_W | Oldest queued packet number |
| head_valid | output | 1 | Completion queue holds an entry |
| stat_tx | output | 1 | TX interrupt status |
| stat_txempty | output | 1 | TX-empty interrupt status |
| stat_rx | output | 1 | RX interrupt status |
| irq | output | 1 | Combined masked interrupt |
| rel_valid | output | 1 | Memory-release request strobe |
| rel_pkt | output | PKT_W | Packet number to release |

## Verification
A bad read or write pointer shows at `head_pkt` as a packet number out of order on the first pop that reaches the bad entry. A bad occupancy count shows as `head_valid` and `stat_tx` disagreeing with a model of the queue, within one cycle of the push or pop that corrupted it. A wrong routing choice appears one clock after the event, either as a missing or spurious `rel_valid` or as an extra or missing queue entry. A masking fault shows at `irq` in the same cycle as the status bits.

// File: rtl/txc_pkg.sv
package txc_pkg;
    localparam int NUM_IRQ = 3;
    localparam int IRQ_TX  = 0;
    localparam int IRQ_TXE = 1;
    localparam int IRQ_RX  = 2;

    typedef struct packed {
        logic rx;
        logic txe;
        logic tx;
    } irq_vec_t;
endpackage

// File: rtl/txc_route.sv
module txc_route #(
    parameter int PKT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_valid,
    input  logic [PKT_W-1:0] done_pkt,
    input  logic             done_ok,
    input  logic             auto_release,
    output logic             push,
    output logic [PKT_W-1:0] push_pkt,
    output logic             rel_valid,
    output logic [PKT_W-1:0] rel_pkt
);
    typedef struct packed {
        logic             vld;
        logic [PKT_W-1:0] pkt;
    } rel_t;

    rel_t rel_d, rel_q;
    logic bypass;

    always_comb begin
        bypass   = auto_release && done_ok;
        push     = done_valid && !bypass;
        push_pkt = done_pkt;
        rel_d     = rel_q;
        rel_d.vld = done_valid && bypass;
        if (done_valid && bypass) begin
            rel_d.pkt = done_pkt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel_q <= '0;
        end else begin
            rel_q <= rel_d;
        end
    end

    assign rel_valid = rel_q.vld;
    assign rel_pkt   = rel_q.pkt;
endmodule

// File: rtl/txc_queue.sv
module txc_queue #(
    parameter int PKT_W = 4,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [PKT_W-1:0] push_pkt,
    input  logic             pop,
    output logic [PKT_W-1:0] head_pkt,
    output logic             head_valid,
    output logic             nonempty_next
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][PKT_W-1:0] mem;
        logic [IDX_W-1:0]            wr;
        logic [IDX_W-1:0]            rd;
        logic [CNT_W-1:0]            cnt;
    } q_t;

    q_t q_d, q_q;
    logic pop_eff;
    logic push_eff;

    function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] i);
        if (i == LAST_IDX) begin
            return '0;
        end
        return i + 1'b1;
    endfunction

    always_comb begin
        q_d      = q_q;
        pop_eff  = pop && (q_q.cnt != '0);
        push_eff = push && ((q_q.cnt != FULL_CNT) || pop_eff);
        if (push_eff) begin
            q_d.mem[q_q.wr] = push_pkt;
            q_d.wr          = step_idx(q_q.wr);
        end
        if (pop_eff) begin
            q_d.rd = step_idx(q_q.rd);
        end
        q_d.cnt = q_q.cnt + CNT_W'(push_eff) - CNT_W'(pop_eff);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign head_pkt      = q_q.mem[q_q.rd];
    assign head_valid    = (q_q.cnt != '0);
    assign nonempty_next = (q_d.cnt != '0);
endmodule

// File: rtl/txc_status.sv
module txc_status
    import txc_pkg::*;
#(
    parameter int OCC_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cq_nonempty_next,
    input  logic [OCC_W-1:0]   txq_count,
    input  logic [OCC_W-1:0]   rxq_count,
    input  logic [NUM_IRQ-1:0] irq_en,
    output irq_vec_t           stat,
    output logic               irq
);
    typedef struct packed {
        irq_vec_t st;
        logic     line;
    } stat_t;

    stat_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.st.tx  = cq_nonempty_next;
        s_d.st.txe = (txq_count == '0);
        s_d.st.rx  = (rxq_count != '0);
        s_d.line   = (s_d.st.tx  && irq_en[IRQ_TX])
                  || (s_d.st.txe && irq_en[IRQ_TXE])
                  || (s_d.st.rx  && irq_en[IRQ_RX]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign stat = s_q.st;
    assign irq  = s_q.line;
endmodule

// File: rtl/txc_irq_unit.sv
module txc_irq_unit
    import txc_pkg::*;
#(
    parameter int PKT_W = 4,
    parameter int DEPTH = 16,
    parameter int OCC_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               done_valid,
    input  logic [PKT_W-1:0]   done_pkt,
    input  logic               done_ok,
    input  logic               auto_release,
    input  logic               host_pop,
    input  logic [OCC_W-1:0]   txq_count,
    input  logic [OCC_W-1:0]   rxq_count,
    input  logic [NUM_IRQ-1:0] irq_en,
    output logic [PKT_W-1:0]   head_pkt,
    output logic               head_valid,
    output logic               stat_tx,
    output logic               stat_txempty,
    output logic               stat_rx,
    output logic               irq,
    output logic               rel_valid,
    output logic [PKT_W-1:0]   rel_pkt
);
    logic             push;
    logic [PKT_W-1:0] push_pkt;
    logic             cq_nonempty_next;
    irq_vec_t         stat;

    txc_route #(.PKT_W(PKT_W)) route_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .done_valid   (done_valid),
        .done_pkt     (done_pkt),
        .done_ok      (done_ok),
        .auto_release (auto_release),
        .push         (push),
        .push_pkt     (push_pkt),
        .rel_valid    (rel_valid),
        .rel_pkt      (rel_pkt)
    );

    txc_queue #(.PKT_W(PKT_W), .DEPTH(DEPTH)) queue_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .push          (push),
        .push_pkt      (push_pkt),
        .pop           (host_pop),
        .head_pkt      (head_pkt),
        .head_valid    (head_valid),
        .nonempty_next (cq_nonempty_next)
    );

    txc_status #(.OCC_W(OCC_W)) status_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .cq_nonempty_next (cq_nonempty_next),
        .txq_count        (txq_count),
        .rxq_count        (rxq_count),
        .irq_en           (irq_en),
        .stat             (stat),
        .irq              (irq)
    );

    assign stat_tx      = stat.tx;
    assign stat_txempty = stat.txe;
    assign stat_rx      = stat.rx;
endmodule

// File: rtl/txc_irq_unit_chk.sv
module txc_irq_unit_chk #(
    parameter int PKT_W = 4,
    parameter int OCC_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             done_valid,
    input logic [PKT_W-1:0] done_pkt,
    input logic             done_ok,
    input logic             auto_release,
    input logic             host_pop,
    input logic [OCC_W-1:0] txq_count,
    input logic [OCC_W-1:0] rxq_count,
    input logic [2:0]       irq_en,
    input logic [PKT_W-1:0] head_pkt,
    input logic             head_valid,
    input logic             stat_tx,
    input logic             stat_txempty,
    input logic             stat_rx,
    input logic             irq,
    input logic             rel_valid,
    input logic [PKT_W-1:0] rel_pkt
);
    // R6
    tx_stat_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_tx == head_valid);

    // R3
    release_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_ok && auto_release) |=> (rel_valid && rel_pkt == $past(done_pkt)));

    // R3
    no_spurious_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_valid && done_ok && auto_release) |=> !rel_valid);

    // R2
    push_to_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !auto_release && !head_valid) |=> (head_valid && head_pkt == $past(done_pkt)));

    // R5
    pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_pop && !head_valid && !done_valid) |=> !head_valid);

    // R7
    txempty_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stat_txempty == ($past(txq_count) == '0)));

    // R8
    rx_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stat_rx == ($past(rxq_count) != '0)));

    // R9
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == ((stat_tx && $past(irq_en[0])) || (stat_txempty && $past(irq_en[1]))
                          || (stat_rx && $past(irq_en[2])))));
endmodule

bind txc_irq_unit txc_irq_unit_chk #(.PKT_W(PKT_W), .OCC_W(OCC_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .done_valid   (done_valid),
    .done_pkt     (done_pkt),
    .done_ok      (done_ok),
    .auto_release (auto_release),
    .host_pop     (host_pop),
    .txq_count    (txq_count),
    .rxq_count    (rxq_count),
    .irq_en       (irq_en),
    .head_pkt     (head_pkt),
    .head_valid   (head_valid),
    .stat_tx      (stat_tx),
    .stat_txempty (stat_txempty),
    .stat_rx      (stat_rx),
    .irq          (irq),
    .rel_valid    (rel_valid),
    .rel_pkt      (rel_pkt)
);

// File: tb/txc_irq_unit_test.sv
module txc_irq_unit_test;
    localparam int CLK_P = 10;
    localparam int PKT_W = 4;
    localparam int DEPTH = 16;
    localparam int OCC_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             done_valid = 1'b0;
    logic [PKT_W-1:0] done_pkt = '0;
    logic             done_ok = 1'b0;
    logic             auto_release = 1'b0;
    logic             host_pop = 1'b0;
    logic [OCC_W-1:0] txq_count = '0;
    logic [OCC_W-1:0] rxq_count = '0;
    logic [2:0]       irq_en = '0;
    logic [PKT_W-1:0] head_pkt;
    logic             head_valid;
    logic             stat_tx;
    logic             stat_txempty;
    logic             stat_rx;
    logic             irq;
    logic             rel_valid;
    logic [PKT_W-1:0] rel_pkt;

    int vectors = 0;
    int errors  = 0;
    logic [PKT_W-1:0] mq[$];

    txc_irq_unit #(.PKT_W(PKT_W), .DEPTH(DEPTH), .OCC_W(OCC_W)) uut (
        .clk(clk), .rst_n(rst_n), .done_valid(done_valid), .done_pkt(done_pkt),
        .done_ok(done_ok), .auto_release(auto_release), .host_pop(host_pop),
        .txq_count(txq_count), .rxq_count(rxq_count), .irq_en(irq_en),
        .head_pkt(head_pkt), .head_valid(head_valid), .stat_tx(stat_tx),
        .stat_txempty(stat_txempty), .stat_rx(stat_rx), .irq(irq),
        .rel_valid(rel_valid), .rel_pkt(rel_pkt)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: inputs set at negedge, model updated, outputs compared after the edge
    task automatic cycle(input logic dv, input logic [PKT_W-1:0] pk, input logic ok,
                         input logic ar, input logic pp, input logic [OCC_W-1:0] tq,
                         input logic [OCC_W-1:0] rq, input logic [2:0] en);
        logic e_rel, e_tx, e_txe, e_rx, e_irq, pushq;
        @(negedge clk);
        done_valid = dv; done_pkt = pk; done_ok = ok; auto_release = ar;
        host_pop = pp; txq_count = tq; rxq_count = rq; irq_en = en;
        e_rel = dv && ok && ar;
        pushq = dv && !(ar && ok);
        if (pp && mq.size() != 0) void'(mq.pop_front());
        if (pushq) mq.push_back(pk);
        e_tx  = (mq.size() != 0);
        e_txe = (tq == 0);
        e_rx  = (rq != 0);
        e_irq = (e_tx && en[0]) || (e_txe && en[1]) || (e_rx && en[2]);
        @(posedge clk);
        #1;
        chk("R2 head_valid", int'(head_valid), int'(e_tx));
        if (e_tx) chk("R2 head_pkt", int'(head_pkt), int'(mq[0]));
        chk("R3 rel_valid", int'(rel_valid), int'(e_rel));
        if (e_rel) chk("R3 rel_pkt", int'(rel_pkt), int'(pk));
        chk("R6 stat_tx", int'(stat_tx), int'(e_tx));
        chk("R7 stat_txempty", int'(stat_txempty), int'(e_txe));
        chk("R8 stat_rx", int'(stat_rx), int'(e_rx));
        chk("R9 irq", int'(irq), int'(e_irq));
    endtask

    task automatic idle();
        cycle(1'b0, '0, 1'b0, 1'b0, 1'b0, 5'd1, 5'd0, 3'b000);
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        // R1: outputs low under reset
        repeat (3) @(posedge clk);
        #1;
        chk("R1 head_valid", int'(head_valid), 0);
        chk("R1 stat_tx", int'(stat_tx), 0);
        chk("R1 stat_txempty", int'(stat_txempty), 0);
        chk("R1 stat_rx", int'(stat_rx), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 rel_valid", int'(rel_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle();

        // R5: pop on empty, then a single push shows exactly once
        cycle(1'b0, '0, 1'b0, 1'b0, 1'b1, 5'd1, 5'd0, 3'b001);
        chk("R5 empty pop head_valid", int'(head_valid), 0);
        cycle(1'b1, 4'd9, 1'b1, 1'b0, 1'b0, 5'd1, 5'd0, 3'b001);
        cycle(1'b0, '0, 1'b0, 1'b0, 1'b1, 5'd1, 5'd0, 3'b001);
        chk("R5 single entry gone", int'(head_valid), 0);

        // R11: fill to DEPTH, drain in order
        for (int i = 0; i < DEPTH; i++)
            cycle(1'b1, PKT_W'(DEPTH - 1 - i), 1'b1, 1'b0, 1'b0, 5'd2, 5'd0, 3'b111);
        for (int i = 0; i < DEPTH; i++) begin
            chk("R11 drain order", int'(head_pkt), DEPTH - 1 - i);
            cycle(1'b0, '0, 1'b0, 1'b0, 1'b1, 5'd2, 5'd0, 3'b111);
        end
        chk("R11 drained", int'(head_valid), 0);

        // R4: auto release with failure is queued, no release
        cycle(1'b1, 4'd5, 1'b0, 1'b1, 1'b0, 5'd0, 5'd0, 3'b000);
        chk("R4 failed queued", int'(head_valid), 1);
        chk("R4 failed head", int'(head_pkt), 5);
        chk("R4 no release", int'(rel_valid), 0);

        // R10: push and pop together keep occupancy
        cycle(1'b1, 4'd6, 1'b0, 1'b0, 1'b0, 5'd0, 5'd0, 3'b000);
        cycle(1'b1, 4'd7, 1'b1, 1'b0, 1'b1, 5'd0, 5'd0, 3'b000);
        chk("R10 head after swap", int'(head_pkt), 6);
        cycle(1'b0, '0, 1'b0, 1'b0, 1'b1, 5'd0, 5'd0, 3'b000);
        chk("R10 next head", int'(head_pkt), 7);
        cycle(1'b0, '0, 1'b0, 1'b0, 1'b1, 5'd0, 5'd0, 3'b000);
        chk("R10 empty", int'(head_valid), 0);

        // sweep over every combination of control inputs, queue state evolving
        for (int rep = 0; rep < 4; rep++) begin
            for (int c = 0; c < 512; c++) begin
                logic dv, ok, ar, pp;
                logic [2:0] en;
                logic [OCC_W-1:0] tq, rq;
                dv = c[0]; ok = c[1]; ar = c[2];
                pp = c[3] && (rep[0] ? (c[5:4] == 2'b00) : 1'b1);
                en = c[6:4];
                tq = c[7] ? OCC_W'((c + rep) % 31 + 1) : '0;
                rq = c[8] ? OCC_W'((c * 3 + rep) % 31 + 1) : '0;
                if (mq.size() == DEPTH && !pp) dv = 1'b0;
                cycle(dv, PKT_W'(c + rep), ok, ar, pp, tq, rq, en);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule